// File: doc/BRIEF.md
# ALU with Registered Status Flags

This block is an 8-bit arithmetic and logic unit for a small processor datapath, paired with a four-bit status register. Each cycle it takes two operands and an opcode. It presents a combinational result together with a strobe that tells the register file whether to store that result. On the same clock edge as the result write, flag-setting operations capture zero, carry, negative and signed-overflow bits. Downstream branch-condition logic reads those bits combinationally from the register outputs.

Subtraction runs through the same adder as addition, with B inverted and a carry-in of one. The stored carry is turned into a borrow, so after a subtract it reads one exactly when A is below B as unsigned values. Compare is a subtract whose result is thrown away while the flags are kept. The pass-through opcodes for loads, moves and jumps never disturb the flags, so a compare followed by other instructions and then a branch still sees the compare's outcome.

Top module: `alu_flags_unit`

## Requirements
- R1: ADD (opcode 0) gives result (A+B) mod 256, and the next flags value has C equal to the carry out of bit 7.
- R2: SUB (opcode 1) gives result (A-B) mod 256, and the next C is 1 exactly when A < B as unsigned (borrow convention).
- R3: After ADD, SUB or CMP, V is 1 exactly when the signed two's-complement result does not fit in 8 bits.
- R4: After every flag-setting opcode, Z is 1 exactly when the 8-bit result is 0x00, and N equals bit 7 of the result.
- R5: AND (2), OR (3) and XOR (4) give the bitwise result, update Z and N from it, and clear C and V.
- R6: CMP (opcode 5) drives the A-B difference on the result port, updates all four flags as SUB would, and holds the result-write strobe low.
- R7: LOAD (6, result = B), MOVE (7, result = A), JUMP (8, result = B) and any undefined opcode 9..15 (result 0x00) leave all four flags unchanged.
- R8: The result-write strobe is 1 for opcodes 0,1,2,3,4,6,7 and 0 for 5, 8 and 9..15.
- R9: A synchronous active-high reset clears all four flags. Flags change only on a rising clock edge, so an operation's flags become visible in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 8 | Operand A |
| opB | input | 8 | Operand B |
| opCode | input | 4 | Operation select |
| result | output | 8 | Combinational operation result |
| resultWr | output | 1 | Result-write strobe for the register file |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry/borrow flag |
| flagN | output | 1 | Registered negative flag |
| flagV | output | 1 | Registered signed-overflow flag |

## Verification
The embedded properties check on every cycle that the flags hold whenever no flag write is strobed, and that Z and N track the previous result. They also check that the carry and borrow match an unsigned comparison of the operands, that signed overflow matches the sign pattern of operands and result, that logic operations clear C and V, and that compare never raises the write strobe. Only the bench's scenarios can show the end-to-end cases. These include the fixed arithmetic corners (127+1, 8+8, 0-1, equal compares), flags set by one operation surviving a run of loads, moves, jumps and undefined codes, and a reset arriving in the middle of traffic.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_LOAD = 4'd6,
    OP_MOVE = 4'd7,
    OP_JUMP = 4'd8
  } opcode_e;

  typedef enum logic [2:0] {
    SEL_ARITH = 3'd0,
    SEL_AND   = 3'd1,
    SEL_OR    = 3'd2,
    SEL_XOR   = 3'd3,
    SEL_PASSA = 3'd4,
    SEL_PASSB = 3'd5,
    SEL_ZERO  = 3'd6
  } resSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e resSel;
    logic    subMode;
    logic    flagWr;
    logic    resWr;
  } strobe_t;

endpackage

// File: rtl/alu_flags_ctrl.sv
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opCode,
  output strobe_t    strb
);

  always_comb begin
    strb = '{resSel: SEL_ZERO, subMode: 1'b0, flagWr: 1'b0, resWr: 1'b0};
    case (opCode)
      OP_ADD:  strb = '{resSel: SEL_ARITH, subMode: 1'b0, flagWr: 1'b1, resWr: 1'b1};
      OP_SUB:  strb = '{resSel: SEL_ARITH, subMode: 1'b1, flagWr: 1'b1, resWr: 1'b1};
      OP_AND:  strb = '{resSel: SEL_AND,   subMode: 1'b0, flagWr: 1'b1, resWr: 1'b1};
      OP_OR:   strb = '{resSel: SEL_OR,    subMode: 1'b0, flagWr: 1'b1, resWr: 1'b1};
      OP_XOR:  strb = '{resSel: SEL_XOR,   subMode: 1'b0, flagWr: 1'b1, resWr: 1'b1};
      OP_CMP:  strb = '{resSel: SEL_ARITH, subMode: 1'b1, flagWr: 1'b1, resWr: 1'b0};
      OP_LOAD: strb = '{resSel: SEL_PASSB, subMode: 1'b0, flagWr: 1'b0, resWr: 1'b1};
      OP_MOVE: strb = '{resSel: SEL_PASSA, subMode: 1'b0, flagWr: 1'b0, resWr: 1'b1};
      OP_JUMP: strb = '{resSel: SEL_PASSB, subMode: 1'b0, flagWr: 1'b0, resWr: 1'b0};
      default: strb = '{resSel: SEL_ZERO,  subMode: 1'b0, flagWr: 1'b0, resWr: 1'b0};
    endcase
  end

  // R6: compare never requests a register write
  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (opCode == OP_CMP) |-> !strb.resWr);

  // R7: pass-through and undefined codes never request a flag write
  a_r7_no_flag_strobe: assert property (@(posedge clk) disable iff (rst)
    (opCode >= OP_LOAD) |-> !strb.flagWr);

  // R8: write strobe set for the storing opcodes
  a_r8_write_ops: assert property (@(posedge clk) disable iff (rst)
    ((opCode <= OP_XOR) || (opCode == OP_LOAD) || (opCode == OP_MOVE)) |-> strb.resWr);

endmodule

// File: rtl/alu_flags_dpath.sv
module alu_flags_dpath
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobe_t          strb,
  output logic [WIDTH-1:0] result,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagN,
  output logic             flagV
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic             isArith;
  logic             isLogic;
  logic             nextZ, nextC, nextN, nextV;

  assign bEff     = strb.subMode ? ~opB : opB;
  assign carry[0] = strb.subMode;

  // Ripple chain of full adders
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum[i]     = opA[i] ^ bEff[i] ^ carry[i];
    assign carry[i+1] = (opA[i] & bEff[i]) | (carry[i] & (opA[i] ^ bEff[i]));
  end

  assign isArith = (strb.resSel == SEL_ARITH);
  assign isLogic = (strb.resSel == SEL_AND) || (strb.resSel == SEL_OR) ||
                   (strb.resSel == SEL_XOR);

  always_comb begin
    case (strb.resSel)
      SEL_ARITH: result = sum;
      SEL_AND:   result = opA & opB;
      SEL_OR:    result = opA | opB;
      SEL_XOR:   result = opA ^ opB;
      SEL_PASSA: result = opA;
      SEL_PASSB: result = opB;
      default:   result = '0;
    endcase
  end

  assign nextZ = ~|result;
  assign nextN = result[MSB];
  assign nextC = isArith & (carry[WIDTH] ^ strb.subMode);
  assign nextV = isArith & (carry[WIDTH] ^ carry[WIDTH-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      flagZ <= 1'b0;
      flagC <= 1'b0;
      flagN <= 1'b0;
      flagV <= 1'b0;
    end else if (strb.flagWr) begin
      flagZ <= nextZ;
      flagC <= nextC;
      flagN <= nextN;
      flagV <= nextV;
    end
  end

  // R9: reset clears all flags
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> ({flagZ, flagC, flagN, flagV} == 4'b0000));

  // R7: flags hold without a flag write
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.flagWr |=> $stable({flagZ, flagC, flagN, flagV}));

  // R4: zero flag follows the written result
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    strb.flagWr |=> (flagZ == ($past(result) == '0)));

  // R4: negative flag follows the result sign bit
  a_r4_neg: assert property (@(posedge clk) disable iff (rst)
    strb.flagWr |=> (flagN == $past(result[MSB])));

  // R5: logic ops clear carry and overflow
  a_r5_logic_clear: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && isLogic) |=> (!flagC && !flagV));

  // R1: add carry equals unsigned overflow of the operands
  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && isArith && !strb.subMode) |=>
      (flagC == (({1'b0, $past(opA)} + {1'b0, $past(opB)}) > {1'b0, {WIDTH{1'b1}}})));

  // R2: subtract carry is the unsigned borrow
  a_r2_sub_borrow: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && strb.subMode) |=> (flagC == ($past(opA) < $past(opB))));

  // R3: add overflow from sign pattern
  a_r3_add_ovf: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && isArith && !strb.subMode) |=>
      (flagV == (($past(opA[MSB]) == $past(opB[MSB])) &&
                 ($past(result[MSB]) != $past(opA[MSB])))));

  // R3: subtract overflow from sign pattern
  a_r3_sub_ovf: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && strb.subMode) |=>
      (flagV == (($past(opA[MSB]) != $past(opB[MSB])) &&
                 ($past(result[MSB]) != $past(opA[MSB])))));

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             resultWr,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagN,
  output logic             flagV
);

  strobe_t strb;

  alu_flags_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opCode (opCode),
    .strb   (strb)
  );

  alu_flags_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .opA    (opA),
    .opB    (opB),
    .strb   (strb),
    .result (result),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagN  (flagN),
    .flagV  (flagV)
  );

  assign resultWr = strb.resWr;

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [3:0] opCode = 4'd0;
  logic [7:0] result;
  logic       resultWr;
  logic       flagZ, flagC, flagN, flagV;

  int checks = 0;
  int errors = 0;

  // reference flag state
  int mZ = 0, mC = 0, mN = 0, mV = 0;

  always #2 clk = ~clk;  // 4 ns period

  alu_flags_unit dut_i (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .resultWr(resultWr),
    .flagZ(flagZ), .flagC(flagC), .flagN(flagN), .flagV(flagV)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string opTag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int expResult(input int op, input int a, input int b);
    case (op)
      0: return (a + b) % 256;
      1, 5: return (a - b + 256) % 256;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      6, 8: return b;
      7: return a;
      default: return 0;
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Drive one operation, check comb outputs, then flags after the edge
  task automatic step(input int op, input int a, input int b);
    int r, wr, nZ, nC, nN, nV, s;
    string t;
    @(negedge clk);
    opCode = op[3:0]; opA = a[7:0]; opB = b[7:0];
    #1;
    r  = expResult(op, a, b);
    wr = (op <= 4 || op == 6 || op == 7) ? 1 : 0;
    t  = opTag(op);
    chk({t, " result"}, int'(result), r);
    chk("R8 resultWr", int'(resultWr), wr);
    nZ = mZ; nC = mC; nN = mN; nV = mV;
    if (op <= 5) begin
      nZ = (r == 0);
      nN = r / 128;
      if (op == 0) begin
        nC = (a + b) > 255;
        s = sx(a) + sx(b);
        nV = (s > 127 || s < -128);
      end else if (op == 1 || op == 5) begin
        nC = (a < b);
        s = sx(a) - sx(b);
        nV = (s > 127 || s < -128);
      end else begin
        nC = 0; nV = 0;
      end
    end
    @(posedge clk);
    #1;
    mZ = nZ; mC = nC; mN = nN; mV = nV;
    chk("R4 flagZ", int'(flagZ), mZ);
    chk("R4 flagN", int'(flagN), mN);
    chk({t, " flagC"}, int'(flagC), mC);
    chk((op >= 2 && op <= 4) ? "R5 flagV" : ((op >= 6) ? "R7 flagV" : "R3 flagV"),
        int'(flagV), mV);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    mZ = 0; mC = 0; mN = 0; mV = 0;
    chk("R9 reset flags", int'({flagZ, flagC, flagN, flagV}), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // worked corners
    step(0, 127, 1);   // R3: 0x80, Z0 C0 N1 V1
    chk("R3 overflow after 127+1", int'(flagV), 1);
    step(0, 8, 8);     // R1: 0x10 all clear
    chk("R1 flags after 8+8", int'({flagZ, flagC, flagN, flagV}), 0);
    step(1, 0, 1);     // R2: 0xFF, C1 N1
    chk("R2 borrow after 0-1", int'({flagZ, flagC, flagN, flagV}), 4'b0110);
    step(0, 255, 1);   // R1 carry, R4 zero
    step(1, 128, 1);   // R3 sub overflow
    step(5, 42, 42);   // R6 equal compare sets Z
    chk("R6 cmp equal Z", int'(flagZ), 1);
    // R7: flags survive non-flag ops
    step(0, 127, 1);
    for (int op = 6; op < 16; op++) step(op, 8'h5A, 8'hA5);
    chk("R7 flags held", int'({flagZ, flagC, flagN, flagV}), 4'b0011);
    // R5 logic clears C and V
    step(1, 0, 1);
    step(2, 8'hF0, 8'h0F);
    step(3, 8'h80, 8'h01);
    step(4, 8'h3C, 8'h3C);
    // random sweep
    for (int i = 0; i < 2000; i++) begin
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)));
      if (i == 1000) doReset();
    end
    // R9 reset after nonzero flags
    step(1, 0, 1);
    doReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule